// File: doc/BRIEF.md
# Chained LCD Column Data Driver

This block holds one display line of pixel data for a 64-column slice of a dot-matrix LCD. It drives a 2-bit drive-level code onto each column. Several slices share one 4-bit data bus and sit on an enable chain. A slice takes nibbles from the bus only while its incoming enable is high. After its sixteenth nibble it passes the enable to the next slice. A line controller streams a whole row across all slices, then issues a latch pulse. On that pulse every slice moves its captured row to the column outputs and drops its outgoing enable, so the next row starts again at the first slice.

All strobes (shift clock, enable clock, latch pulse) are sampled by one system clock, and the block acts on their falling edges. Each column code is taken from the latched pixel and the AC frame input. The frame input flips drive polarity every frame, so the panel sees no DC bias.

Top module: `lcdcol_drv`

## Requirements
- R1: A synchronous reset clears the captured row, the latched row, the nibble counter and `chain_out_o`. After reset every column shows the dark code for the current frame.
- R2: On a shift-clock falling edge with `chain_in_i` high and fewer than 16 nibbles taken, nibble k of the line (k = 0 for the first) is stored with bit i going to column 4k+i.
- R3: Shift-clock falling edges while `chain_in_i` is low store nothing and do not advance the nibble counter.
- R4: After 16 nibbles have been taken, further shift-clock falling edges are ignored until the next latch-pulse falling edge.
- R5: `chain_out_o` rises only on an enable-clock falling edge that arrives after the 16th nibble has been taken. Enable-clock edges before that leave it low.
- R6: On a latch-pulse falling edge `chain_out_o` goes low and the nibble counter returns to zero. The next line's first nibble then lands in columns 0 to 3.
- R7: The latched row, and so each column code for a fixed frame value, changes only on a latch-pulse falling edge. Rising edges of the latch pulse and loading a new row have no effect on it.
- R8: Column c drives `lvl_o[2c+1:2c]`. With frame 0, a lit pixel gives 2'b11 (lowest level, negative supply) and a dark pixel gives 2'b01 (V2). With frame 1, a lit pixel gives 2'b00 (highest level, logic rail) and a dark pixel gives 2'b10 (V3).
- R9: When a latch-pulse falling edge and a shift-clock falling edge fall in the same system-clock cycle, the latch acts and the nibble is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst | input | 1 | Synchronous active-high reset |
| nib_i | input | 4 | Display data nibble |
| shclk_i | input | 1 | Shift clock; data taken on its falling edge |
| lpulse_i | input | 1 | Line latch pulse; acts on its falling edge |
| frame_i | input | 1 | AC polarity select for the drive codes |
| chain_in_i | input | 1 | Active-high enable from the previous slice |
| chclk_i | input | 1 | Enable clock; chain state advances on its falling edge |
| chain_out_o | output | 1 | Active-high enable to the next slice |
| lvl_o | output | 128 | Two-bit drive-level code per column, column c at bits 2c+1:2c |

## Verification
The checker watches several rules on every cycle. The latched row never moves without a latch edge, and the nibble counter freezes while the slice is disabled or full. The outgoing enable only rises on an enable-clock edge while full and never outlives the latch pulse. Every column code carries the polarity bit the frame input demands. Other behaviours need the bench's scenarios, because they compare whole lines against independently computed pixel positions: the nibble-to-column mapping, the discarded nibble when latch and shift coincide, and the rejection of surplus or disabled nibbles.

// File: rtl/lcdcol_pkg.sv
package lcdcol_pkg;
   // drive levels, highest potential first
   typedef enum logic [1:0] {
      LVL_RAIL = 2'b00,
      LVL_MIDH = 2'b01,
      LVL_MIDL = 2'b10,
      LVL_NEG  = 2'b11
   } lvl_e;

   function automatic lvl_e pick_level(input logic lit, input logic frame);
      if (frame)
         return lit ? LVL_RAIL : LVL_MIDL;
      else
         return lit ? LVL_NEG : LVL_MIDH;
   endfunction
endpackage

// File: rtl/lcdcol_fall.sv
module lcdcol_fall #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] sig,
   output logic [W-1:0] fall
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst) prev_q <= '0;
      else     prev_q <= sig;
   end

   assign fall = prev_q & ~sig;
endmodule

// File: rtl/lcdcol_chain.sv
module lcdcol_chain #(
   parameter int SLOTS = 16,
   localparam int CW   = $clog2(SLOTS + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          sh_fall,
   input  logic          lp_fall,
   input  logic          ec_fall,
   input  logic          chain_in,
   output logic          wr_en,
   output logic [CW-1:0] wr_slot,
   output logic          full,
   output logic          chain_out
);
   logic [CW-1:0] cnt_q;
   logic          eo_q;

   assign full    = (cnt_q == CW'(SLOTS));
   assign wr_en   = sh_fall & chain_in & ~full & ~lp_fall;
   assign wr_slot = cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         eo_q  <= 1'b0;
      end else if (lp_fall) begin
         cnt_q <= '0;
         eo_q  <= 1'b0;
      end else begin
         if (wr_en)           cnt_q <= cnt_q + 1'b1;
         if (ec_fall && full) eo_q  <= 1'b1;
      end
   end

   assign chain_out = eo_q;
endmodule

// File: rtl/lcdcol_store.sv
module lcdcol_store #(
   parameter int COLS = 64,
   parameter int NIB  = 4,
   localparam int SLOTS = COLS / NIB,
   localparam int CW    = $clog2(SLOTS + 1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [CW-1:0]   wr_slot,
   input  logic [NIB-1:0]  nib,
   input  logic            lp_fall,
   output logic [COLS-1:0] latched
);
   logic [COLS-1:0] row;
   logic [COLS-1:0] lat_q;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [NIB-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (rst)                               slot_q <= '0;
         else if (wr_en && wr_slot == CW'(g))   slot_q <= nib;
      end
      assign row[g*NIB +: NIB] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (rst)          lat_q <= '0;
      else if (lp_fall) lat_q <= row;
   end

   assign latched = lat_q;
endmodule

// File: rtl/lcdcol_encode.sv
module lcdcol_encode
   import lcdcol_pkg::*;
#(
   parameter int COLS = 64
) (
   input  logic [COLS-1:0]   latched,
   input  logic              frame,
   output logic [2*COLS-1:0] lvl
);
   for (genvar c = 0; c < COLS; c++) begin : g_col
      assign lvl[2*c +: 2] = pick_level(latched[c], frame);
   end
endmodule

// File: rtl/lcdcol_drv.sv
module lcdcol_drv #(
   parameter int COLS = 64,
   parameter int NIB  = 4,
   localparam int SLOTS = COLS / NIB,
   localparam int CW    = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [3:0]        nib_i,
   input  logic              shclk_i,
   input  logic              lpulse_i,
   input  logic              frame_i,
   input  logic              chain_in_i,
   input  logic              chclk_i,
   output logic              chain_out_o,
   output logic [2*COLS-1:0] lvl_o
);
   if (NIB != 4) begin : g_bad_nib
      $error("lcdcol_drv: bus width must be 4");
   end
   if (COLS % NIB != 0 || COLS < NIB) begin : g_bad_cols
      $error("lcdcol_drv: COLS must be a multiple of NIB");
   end

   logic [2:0]      falls;
   logic            sh_fall, lp_fall, ec_fall;
   logic            wr_en, full;
   logic [CW-1:0]   wr_slot;
   logic [COLS-1:0] latched;

   lcdcol_fall #(.W(3)) u_fall (
      .clk(clk), .rst(rst),
      .sig({chclk_i, lpulse_i, shclk_i}),
      .fall(falls)
   );
   assign sh_fall = falls[0];
   assign lp_fall = falls[1];
   assign ec_fall = falls[2];

   lcdcol_chain #(.SLOTS(SLOTS)) u_chain (
      .clk(clk), .rst(rst),
      .sh_fall(sh_fall), .lp_fall(lp_fall), .ec_fall(ec_fall),
      .chain_in(chain_in_i),
      .wr_en(wr_en), .wr_slot(wr_slot), .full(full),
      .chain_out(chain_out_o)
   );

   lcdcol_store #(.COLS(COLS), .NIB(NIB)) u_store (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_slot(wr_slot), .nib(nib_i[NIB-1:0]),
      .lp_fall(lp_fall), .latched(latched)
   );

   lcdcol_encode #(.COLS(COLS)) u_enc (
      .latched(latched), .frame(frame_i), .lvl(lvl_o)
   );
endmodule

// File: rtl/lcdcol_drv_chk.sv
module lcdcol_drv_chk #(
   parameter int COLS = 64,
   parameter int CW   = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              chain_in,
   input logic              lp_fall,
   input logic              ec_fall,
   input logic              full,
   input logic [CW-1:0]     cnt,
   input logic              chain_out,
   input logic [COLS-1:0]   latched,
   input logic              frame,
   input logic [2*COLS-1:0] lvl
);
   // R5
   eo_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(chain_out) |-> ($past(ec_fall) && $past(full)));

   // R5
   eo_full_chk: assert property (@(posedge clk) disable iff (rst)
      chain_out |-> full);

   // R6
   lp_clear_chk: assert property (@(posedge clk) disable iff (rst)
      lp_fall |=> (!chain_out && cnt == '0));

   // R7
   latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !lp_fall |=> $stable(latched));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!chain_in && !lp_fall) |=> $stable(cnt));

   // R4
   full_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (full && !lp_fall) |=> $stable(cnt));

   // R8
   always @(posedge clk) begin
      if (!rst) begin
         for (int c = 0; c < COLS; c++) begin
            lvl_pol_chk: assert (lvl[2*c] == !frame);
         end
      end
   end
endmodule

bind lcdcol_drv lcdcol_drv_chk #(.COLS(COLS), .CW(CW)) u_chk (
   .clk(clk), .rst(rst), .chain_in(chain_in_i),
   .lp_fall(lp_fall), .ec_fall(ec_fall), .full(full),
   .cnt(wr_slot), .chain_out(chain_out_o), .latched(latched),
   .frame(frame_i), .lvl(lvl_o)
);

// File: tb/test_lcdcol_drv.sv
module test_lcdcol_drv;
   localparam int COLS = 64;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [3:0]        nib = '0;
   logic              shclk = 1'b0, lpulse = 1'b0, frame = 1'b0;
   logic              ein = 1'b0, eclk = 1'b0;
   logic              eout;
   logic [2*COLS-1:0] lvl;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   lcdcol_drv i_lcdcol_drv (
      .clk(clk), .rst(rst), .nib_i(nib), .shclk_i(shclk),
      .lpulse_i(lpulse), .frame_i(frame), .chain_in_i(ein),
      .chclk_i(eclk), .chain_out_o(eout), .lvl_o(lvl)
   );

   always #5 clk = ~clk;

   localparam logic [63:0] ROWS [6] = '{
      64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
      64'h0000_0000_0000_0000, 64'hA5A5_5A5A_F00F_0FF0,
      64'h8000_0000_0000_0001, 64'h1357_9BDF_2468_ACE0
   };

   // R8: expected column codes
   function automatic logic [2*COLS-1:0] expv(input logic [63:0] r, input logic fr);
      logic [2*COLS-1:0] v;
      for (int c = 0; c < COLS; c++)
         v[2*c +: 2] = fr ? (r[c] ? 2'b00 : 2'b10) : (r[c] ? 2'b11 : 2'b01);
      return v;
   endfunction

   task automatic chk(input string req, input logic [2*COLS-1:0] act, input logic [2*COLS-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic shift_nib(input logic [3:0] d);
      nib = d; shclk = 1'b1; tick();
      shclk = 1'b0; tick();
   endtask

   task automatic load(input logic [63:0] r, input int first, input int n, input logic en);
      ein = en;
      for (int k = first; k < first + n; k++) shift_nib(r[4*k +: 4]);
   endtask

   task automatic pulse_ec();
      eclk = 1'b1; tick(); eclk = 1'b0; tick();
   endtask

   task automatic pulse_lp();
      lpulse = 1'b1; tick(); lpulse = 1'b0; tick();
   endtask

   task automatic out_chk(input string req, input logic [63:0] r);
      frame = 1'b0; #1; chk(req, lvl, expv(r, 1'b0));
      frame = 1'b1; #1; chk(req, lvl, expv(r, 1'b1));
      frame = 1'b0; #1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [63:0] prev;
      repeat (3) tick();
      rst = 1'b0; tick();
      // R1 reset state
      out_chk("R1 reset outputs dark", '0);
      chk("R1 reset chain_out", {127'b0, eout}, '0);

      prev = '0;
      for (int i = 0; i < 6; i++) begin
         load(ROWS[i], 0, 16, 1'b1);
         chk("R5 no enable before enable clock", {127'b0, eout}, '0);
         // R7: new row loaded, latch rising edge only
         lpulse = 1'b1; tick();
         out_chk("R7 outputs hold before latch fall", prev);
         lpulse = 1'b0; eclk = 1'b1; tick();
         out_chk("R2 row latched", ROWS[i]);
         // R6: latch cleared chain before enable clock fell
         eclk = 1'b0; tick();
         chk("R6 chain_out cleared after latch", {127'b0, eout}, '0);
         load(ROWS[i], 0, 16, 1'b1);
         pulse_ec();
         chk("R5 enable after full and clock", {127'b0, eout}, 128'd1);
         pulse_lp();
         chk("R6 chain_out low after latch", {127'b0, eout}, '0);
         out_chk("R8 codes both frames", ROWS[i]);
         prev = ROWS[i];
      end

      // R3: disabled shifts ignored
      load(~prev, 0, 16, 1'b0);
      pulse_ec();
      chk("R3 no fill while disabled", {127'b0, eout}, '0);
      pulse_lp();
      out_chk("R3 row unchanged", prev);

      // R4: surplus nibbles ignored
      load(ROWS[3], 0, 16, 1'b1);
      load(64'hFFFF_FFFF_FFFF_FFFF, 0, 4, 1'b1);
      pulse_lp();
      out_chk("R4 surplus ignored", ROWS[3]);

      // R5: early enable clock
      load(ROWS[0], 0, 15, 1'b1);
      pulse_ec();
      chk("R5 early enable clock", {127'b0, eout}, '0);
      load(ROWS[0], 15, 1, 1'b1);
      chk("R5 full but no enable clock", {127'b0, eout}, '0);
      pulse_ec();
      chk("R5 enable after clock", {127'b0, eout}, 128'd1);
      pulse_lp();
      out_chk("R2 row after split load", ROWS[0]);

      // R9: latch and shift fall together
      ein = 1'b1; nib = 4'h9; shclk = 1'b1; lpulse = 1'b1; tick();
      shclk = 1'b0; lpulse = 1'b0; tick();
      load(ROWS[5], 0, 16, 1'b1);
      pulse_lp();
      out_chk("R9 coincident nibble discarded", ROWS[5]);

      // R1: reset mid-line
      load(ROWS[3], 0, 16, 1'b1);
      pulse_ec();
      rst = 1'b1; tick(); rst = 1'b0; tick();
      out_chk("R1 reset clears latch", '0);
      chk("R1 reset clears chain_out", {127'b0, eout}, '0);
      pulse_lp();
      out_chk("R1 reset clears captured row", '0);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule